// File: doc/BRIEF.md
# Disk Controller Command Handshake Sequencer

This block paces the host side of a command-driven disk controller. The host polls two status bits. `rqm` means the controller is ready for a transfer. `dio` gives the direction: 0 means host to controller, 1 means controller to host. While `rqm` is 1 and `dio` is 0, the host writes one opcode byte followed by that opcode's parameter bytes. Each byte is consumed for one cycle before the next one is requested.

A small internal table gives the parameter count for each known opcode. When the last parameter byte arrives, the sequencer enters the execution phase on its own. It pulses a start strobe and presents the opcode and the collected parameters to the execution engine. When the engine reports completion, the sequencer offers one status byte in the result phase. After the host reads that byte, the sequencer returns to the command phase. An opcode that is not in the table skips execution and goes straight to a result byte that reports the invalid command.

A data FIFO enable request from outside is passed through only outside the command phase.

Top module: `cmd_handshake_seq`

## Requirements
- R1: Out of reset: `phase` is 0 (command), `rqm`=1, `dio`=0, `busy`=0, `exec_start`=0 and `host_rdata`=0.
- R2: A `host_wr` pulse is taken only while `rqm`=1 and `dio`=0. Any other write changes neither the captured bytes nor the phase.
- R3: In the cycle after an accepted write, `rqm` is 0. One cycle later `rqm` is 1 again if more parameter bytes are still owed.
- R4: The table maps opcode 0x08 to 0 parameters, 0x03 to 2 and 0x06 to 8. Parameter byte i appears on `exec_params[8i+7:8i]`, unused bytes read 0, and `exec_opcode` holds the opcode.
- R5: Two cycles after the final byte of a valid command (the opcode itself when it takes 0 parameters), `exec_start` is 1 for exactly one cycle, `phase` is 1 and `rqm` is 0. `rqm` stays 0 for the whole execution phase.
- R6: `fifo_on` equals `fifo_req` while `phase` is 1 or 2, and is 0 while `phase` is 0.
- R7: Two cycles after an opcode that is not in the table is written, `phase` is 2, `rqm`=`dio`=1 and `host_rdata`=0x80. No `exec_start` is produced.
- R8: An `exec_done` pulse during execution loads `exec_status` into the result byte. From the next cycle, `phase` is 2 with `rqm`=`dio`=1. A `host_rd` pulse in the result phase returns the sequencer to `phase` 0 with `rqm`=1 and `dio`=0 in the following cycle.
- R9: `busy` is 1 from the cycle after the opcode write until the return to the command phase, and 0 while waiting for an opcode.
- R10: `host_rd` outside the result phase is ignored, and `host_rdata` is 0 outside the result phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe for the result byte |
| host_rdata | output | 8 | Result byte; 0 outside result phase |
| rqm | output | 1 | Ready-for-transfer status bit |
| dio | output | 1 | Direction status bit, 1 = controller to host |
| busy | output | 1 | Command in progress |
| phase | output | 2 | 0 command, 1 execution, 2 result |
| fifo_req | input | 1 | FIFO enable request from configuration |
| fifo_on | output | 1 | Gated FIFO enable |
| exec_start | output | 1 | One-cycle start pulse to the execution engine |
| exec_opcode | output | 8 | Opcode of the command being executed |
| exec_params | output | 64 | Parameter bytes, byte i at bits 8i+7:8i |
| exec_done | input | 1 | Execution finished, one cycle |
| exec_status | input | 8 | Status byte returned by the execution engine |

## Verification
The assertions assume that the host and the execution engine drive one-cycle strobes. `exec_done` is assumed to arrive only after `exec_start` has been seen. Under those assumptions, writes outside the request window are harmless and the checker does not need to exclude them.

The stimulus keeps `exec_done` inside the execution phase. It also injects writes deliberately into the consumed-byte cycle and the execution phase, and reads into the command phase, so that the ignore rules are exercised. Opcodes are drawn at random from the three table entries and from non-table bytes, and parameter bytes are random.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCEPT,
    ST_PROC,
    ST_EXEC,
    ST_RESULT
  } st_e;

  localparam logic [1:0] PH_CMD  = 2'd0;
  localparam logic [1:0] PH_EXEC = 2'd1;
  localparam logic [1:0] PH_RES  = 2'd2;

  localparam logic [7:0] INVALID_STATUS = 8'h80;

  function automatic logic [1:0] phase_of(st_e s);
    case (s)
      ST_EXEC:   phase_of = PH_EXEC;
      ST_RESULT: phase_of = PH_RES;
      default:   phase_of = PH_CMD;
    endcase
  endfunction

  function automatic logic wants_byte(st_e s);
    wants_byte = (s == ST_IDLE) || (s == ST_ACCEPT);
  endfunction
endpackage

// File: rtl/seq_cmd_table.sv
module seq_cmd_table #(
  parameter int NUM_CMD = 3,
  parameter int CW = 4,
  parameter logic [NUM_CMD*8-1:0]  OPC_LIST = {8'h06, 8'h03, 8'h08},
  parameter logic [NUM_CMD*CW-1:0] CNT_LIST = {4'd8, 4'd2, 4'd0}
) (
  input  logic [7:0]    opcode,
  output logic          hit,
  output logic [CW-1:0] count
);
  logic [NUM_CMD-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_CMD; g++) begin : g_cmp
      assign match[g] = (opcode == OPC_LIST[g*8 +: 8]);
    end
  endgenerate

  always_comb begin
    hit   = |match;
    count = '0;
    for (int i = 0; i < NUM_CMD; i++) begin
      if (match[i]) count = CNT_LIST[i*CW +: CW];
    end
  end
endmodule

// File: rtl/seq_param_store.sv
module seq_param_store #(
  parameter int MAX_PARAMS = 8,
  parameter int CW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [CW-1:0]           idx,
  input  logic [7:0]              din,
  output logic [MAX_PARAMS*8-1:0] flat
);
  genvar g;
  generate
    for (g = 0; g < MAX_PARAMS; g++) begin : g_byte
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
        if (!rst_n || clr)                    b_q <= '0;
        else if (we && idx == CW'(g))         b_q <= din;
      end
      assign flat[g*8 +: 8] = b_q;
    end
  endgenerate
endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import hsk_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_rd,
  input  logic          exec_done,
  input  logic [7:0]    exec_status,
  input  logic          tbl_hit,
  input  logic [CW-1:0] tbl_count,
  output st_e           state,
  output logic [7:0]    opcode_q,
  output logic          store_clr,
  output logic          store_we,
  output logic [CW-1:0] store_idx,
  output logic          exec_start,
  output logic [7:0]    res_byte,
  output logic          byte_taken,
  output logic          bad_cmd
);
  st_e           st_q, st_d;
  logic          first_q;
  logic [CW-1:0] need_q, cnt_q;

  assign state      = st_q;
  assign byte_taken = host_wr && wants_byte(st_q);
  assign bad_cmd    = (st_q == ST_PROC) && first_q && !tbl_hit;
  assign store_clr  = byte_taken && (st_q == ST_IDLE);
  assign store_we   = byte_taken && (st_q == ST_ACCEPT);
  assign store_idx  = cnt_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_ACCEPT: if (byte_taken) st_d = ST_PROC;
      ST_PROC: begin
        if (first_q) begin
          if (!tbl_hit)               st_d = ST_RESULT;
          else if (tbl_count == '0)   st_d = ST_EXEC;
          else                        st_d = ST_ACCEPT;
        end else if (cnt_q == need_q) st_d = ST_EXEC;
        else                          st_d = ST_ACCEPT;
      end
      ST_EXEC:   if (exec_done) st_d = ST_RESULT;
      ST_RESULT: if (host_rd)   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      first_q    <= 1'b0;
      need_q     <= '0;
      cnt_q      <= '0;
      opcode_q   <= '0;
      exec_start <= 1'b0;
      res_byte   <= '0;
    end else begin
      st_q       <= st_d;
      exec_start <= (st_q == ST_PROC) && (st_d == ST_EXEC);
      if (store_clr) begin
        opcode_q <= host_wdata;
        first_q  <= 1'b1;
        cnt_q    <= '0;
      end
      if (store_we) begin
        cnt_q   <= cnt_q + 1'b1;
        first_q <= 1'b0;
      end
      if (st_q == ST_PROC && first_q) need_q <= tbl_count;
      if (bad_cmd) res_byte <= INVALID_STATUS;
      else if (st_q == ST_EXEC && exec_done) res_byte <= exec_status;
    end
  end
endmodule

// File: rtl/cmd_handshake_seq.sv
module cmd_handshake_seq
  import hsk_pkg::*;
#(
  parameter int MAX_PARAMS = 8,
  parameter int CW = $clog2(MAX_PARAMS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_wr,
  input  logic [7:0]              host_wdata,
  input  logic                    host_rd,
  output logic [7:0]              host_rdata,
  output logic                    rqm,
  output logic                    dio,
  output logic                    busy,
  output logic [1:0]              phase,
  input  logic                    fifo_req,
  output logic                    fifo_on,
  output logic                    exec_start,
  output logic [7:0]              exec_opcode,
  output logic [MAX_PARAMS*8-1:0] exec_params,
  input  logic                    exec_done,
  input  logic [7:0]              exec_status
);
  st_e           state;
  logic          tbl_hit;
  logic [CW-1:0] tbl_count;
  logic          store_clr, store_we;
  logic [CW-1:0] store_idx;
  logic [7:0]    res_byte;
  logic          byte_taken, bad_cmd;

  seq_cmd_table #(
    .NUM_CMD (3),
    .CW      (CW),
    .OPC_LIST({8'h06, 8'h03, 8'h08}),
    .CNT_LIST({CW'(8), CW'(2), CW'(0)})
  ) u_table (
    .opcode(exec_opcode),
    .hit   (tbl_hit),
    .count (tbl_count)
  );

  seq_phase_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rd    (host_rd),
    .exec_done  (exec_done),
    .exec_status(exec_status),
    .tbl_hit    (tbl_hit),
    .tbl_count  (tbl_count),
    .state      (state),
    .opcode_q   (exec_opcode),
    .store_clr  (store_clr),
    .store_we   (store_we),
    .store_idx  (store_idx),
    .exec_start (exec_start),
    .res_byte   (res_byte),
    .byte_taken (byte_taken),
    .bad_cmd    (bad_cmd)
  );

  seq_param_store #(.MAX_PARAMS(MAX_PARAMS), .CW(CW)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (store_clr),
    .we   (store_we),
    .idx  (store_idx),
    .din  (host_wdata),
    .flat (exec_params)
  );

  assign phase      = phase_of(state);
  assign rqm        = wants_byte(state) || (state == ST_RESULT);
  assign dio        = (state == ST_RESULT);
  assign busy       = (state != ST_IDLE);
  assign fifo_on    = fifo_req && (phase != PH_CMD);
  assign host_rdata = (state == ST_RESULT) ? res_byte : 8'h00;
endmodule

// File: rtl/cmd_handshake_seq_chk.sv
module cmd_handshake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       rqm,
  input logic       dio,
  input logic       busy,
  input logic [1:0] phase,
  input logic       fifo_on,
  input logic       exec_start,
  input logic [7:0] host_rdata,
  input logic       byte_taken,
  input logic       bad_cmd
);
  a_r2_take_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    byte_taken |-> (host_wr && rqm && !dio));

  a_r3_rqm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    byte_taken |=> !rqm);

  a_r5_exec_no_rqm: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> !rqm);

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  a_r6_fifo_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> !fifo_on);

  a_r7_invalid_result: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> (phase == 2'd2 && host_rdata == 8'h80 && !exec_start));

  a_r8_result_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |-> (rqm && dio));

  a_r9_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rqm && !dio && phase == 2'd0));

  a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd2) |-> (host_rdata == 8'h00));
endmodule

bind cmd_handshake_seq cmd_handshake_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .rqm       (rqm),
  .dio       (dio),
  .busy      (busy),
  .phase     (phase),
  .fifo_on   (fifo_on),
  .exec_start(exec_start),
  .host_rdata(host_rdata),
  .byte_taken(byte_taken),
  .bad_cmd   (bad_cmd)
);

// File: tb/cmd_handshake_seq_tb_top.sv
`timescale 1ns/1ps
module cmd_handshake_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        rqm, dio, busy, fifo_on, exec_start;
  logic [1:0]  phase;
  logic        fifo_req = 1'b0;
  logic [7:0]  exec_opcode;
  logic [63:0] exec_params;
  logic        exec_done = 1'b0;
  logic [7:0]  exec_status = '0;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] pb [8];

  always #2.5 clk = ~clk;

  cmd_handshake_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .rqm(rqm), .dio(dio),
    .busy(busy), .phase(phase), .fifo_req(fifo_req), .fifo_on(fifo_on),
    .exec_start(exec_start), .exec_opcode(exec_opcode),
    .exec_params(exec_params), .exec_done(exec_done), .exec_status(exec_status)
  );

  function automatic int exp_need(logic [7:0] op);
    if (op == 8'h08) return 0;
    if (op == 8'h03) return 2;
    if (op == 8'h06) return 8;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
    end
  end

  // Drive one byte; optionally keep a junk write during the consumed cycle.
  task automatic put_byte(logic [7:0] b, bit junk);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = b;
    @(negedge clk);
    if (junk) host_wdata = ~b;
    else host_wr = 1'b0;
    chk(rqm == 1'b0, "R3", "rqm after write", rqm, 0);
    chk(busy == 1'b1, "R9", "busy after write", busy, 1);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic run_cmd(logic [7:0] op, bit junk, logic [7:0] st);
    int need = exp_need(op);
    chk(rqm && !dio && !busy && phase == 2'd0, "R9", "idle before cmd",
        {busy, rqm, dio}, 3'b010);
    for (int i = 0; i < 8; i++) pb[i] = 8'($urandom);
    put_byte(op, junk);
    if (need < 0) begin
      chk(phase == 2'd2 && rqm && dio, "R7", "invalid phase", phase, 2);
      chk(host_rdata == 8'h80, "R7", "invalid status", host_rdata, 8'h80);
      chk(!exec_start, "R7", "no start", exec_start, 0);
    end else begin
      for (int i = 0; i < need; i++) begin
        chk(rqm && !dio && phase == 2'd0, "R3", "rqm reasserted", rqm, 1);
        put_byte(pb[i], junk && (i == 0));
      end
      chk(exec_start && phase == 2'd1 && !rqm, "R5", "exec entry",
          {exec_start, phase, rqm}, 4'b1010);
      chk(exec_opcode == op, "R4", "opcode", exec_opcode, op);
      for (int i = 0; i < 8; i++) begin
        logic [7:0] e = (i < need) ? pb[i] : 8'h00;
        chk(exec_params[i*8 +: 8] == e, "R4", "param byte", exec_params[i*8 +: 8], e);
      end
      fifo_req = 1'($urandom);
      @(negedge clk);
      chk(!exec_start, "R5", "start one cycle", exec_start, 0);
      chk(fifo_on == fifo_req, "R6", "fifo in exec", fifo_on, fifo_req);
      host_wr = 1'b1; host_wdata = 8'h5a;
      @(negedge clk);
      host_wr = 1'b0;
      chk(phase == 2'd1 && !rqm && exec_opcode == op, "R2", "write in exec ignored",
          phase, 1);
      exec_done = 1'b1; exec_status = st;
      @(negedge clk);
      exec_done = 1'b0;
      chk(phase == 2'd2 && rqm && dio, "R8", "result phase", phase, 2);
      chk(host_rdata == st, "R8", "result byte", host_rdata, st);
    end
    host_wr = 1'b1; host_wdata = 8'h08;
    @(negedge clk);
    host_wr = 1'b0;
    chk(phase == 2'd2 && busy, "R2", "write in result ignored", phase, 2);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk(phase == 2'd0 && rqm && !dio && !busy, "R8", "back to command",
        {phase, rqm, dio, busy}, 5'b00100);
    chk(host_rdata == 8'h00 && !fifo_on, "R10", "quiet in command", host_rdata, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rqm && !dio && !busy && phase == 2'd0 && !exec_start && host_rdata == 0,
        "R1", "reset state", {rqm, dio, busy, phase}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rqm && !dio && !busy, "R1", "after reset", {rqm, dio, busy}, 3'b100);
    fifo_req = 1'b1;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk(phase == 2'd0 && rqm && !busy, "R10", "read in command ignored", phase, 0);
    chk(!fifo_on, "R6", "fifo off in command", fifo_on, 0);
    // Directed corners
    run_cmd(8'h08, 1'b0, 8'h21);
    run_cmd(8'h03, 1'b1, 8'h42);
    run_cmd(8'h06, 1'b0, 8'h00);
    run_cmd(8'hff, 1'b0, 8'h00);
    run_cmd(8'h00, 1'b1, 8'h00);
    // Constrained random
    for (int k = 0; k < 60; k++) begin
      int sel = int'($urandom % 4);
      logic [7:0] op;
      case (sel)
        0: op = 8'h08;
        1: op = 8'h03;
        2: op = 8'h06;
        default: begin
          op = 8'($urandom);
          if (exp_need(op) >= 0) op = op ^ 8'h40;
        end
      endcase
      run_cmd(op, 1'($urandom), 8'($urandom));
    end
    summary();
  end
endmodule